// File: doc/BRIEF.md
# Bus Monitor Logging Sequencer

This block decides which observed bus messages a 1553 bus monitor stores, and gives each stored message its two memory locations. Message events arrive on a stream, one beat per finished message, carrying the 5-bit terminal address of that message. For each message that is stored, the block emits one block descriptor on an output stream. The descriptor carries the word address of an 8-word command record and the word address of a 32-word data area. Bus decoding and the memory writes themselves belong to neighbouring blocks.

Six 16-bit configuration registers are loaded through a plain write port:
- a control register, whose bit 5 selects filtered capture;
- two filter words that together give one enable bit per terminal;
- a block count;
- the initial command pointer;
- the initial data pointer.

While `run` is high, the count steps down once per stored block. A programmed count of N therefore gives N+1 blocks per round. The block that finds the count at zero does three things: it raises a one-cycle interrupt, it sends both pointers back to their initial values, and it reloads the count.

Both streams use valid/ready. The output holds one descriptor. A new message is taken only when that slot is empty or is being emptied in the same cycle. While `blk_valid` is high and `blk_ready` is low, the descriptor must not change.

Top module: `bm_log_seq`

## Requirements
- R1: After reset, `blk_valid` and `cnt_irq` are 0, and every register and pointer is 0, which means all terminals are captured.
- R2: Write select 0 is the control register. Its bit 5 chooses the capture mode: 0 captures messages from every terminal, and 1 captures only terminals whose filter bit is 1.
- R3: Write select 1 holds the filter bits for terminals 0 to 15, with bit i standing for terminal i. Write select 2 holds terminals 16 to 31, with bit i standing for terminal 16+i. A message rejected by the filter is consumed and has no effect: no descriptor, no pointer step, no count change.
- R4: Each stored message yields a descriptor whose two addresses are the current command pointer and data pointer. After it, the command pointer steps by 8 and the data pointer by 32, both modulo 2^16.
- R5: With a programmed count of N (write select 3), each round stores N+1 blocks. The count steps down by one for each stored block.
- R6: `cnt_irq` is high for exactly the cycle in which the descriptor of a block that found the count at zero first appears.
- R7: After the block that found the count at zero, the command pointer and data pointer restart at their initial values (write selects 4 and 5), and the count reloads its programmed value.
- R8: While `run` is high, writes to selects 3, 4 and 5 are ignored, while writes to the control and filter registers still take effect. On the rising edge of `run`, the live count and pointers are loaded from the programmed values. No message is stored in that first cycle.
- R9: `msg_ready` equals `!blk_valid || blk_ready`. While `blk_valid` is high and `blk_ready` is low, the descriptor holds its value.
- R10: While `run` is low, messages are accepted and dropped, with no descriptor and no count or pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 filter low, 2 filter high, 3 count, 4 command pointer, 5 data pointer |
| wr_data | input | 16 | Register write value |
| run | input | 1 | Execution enable |
| msg_valid | input | 1 | Message event valid |
| msg_ready | output | 1 | Message event accepted |
| msg_rt | input | 5 | Terminal address of the message |
| blk_valid | output | 1 | Block descriptor valid |
| blk_ready | input | 1 | Downstream takes descriptor |
| blk_cmd_addr | output | 16 | Command record word address |
| blk_data_addr | output | 16 | Data area word address |
| cnt_irq | output | 1 | Block-count expiry pulse |

## Verification
The assertions check several rules on every cycle:
- the descriptor holds while the output is stalled;
- the interrupt coincides with a valid descriptor;
- each pointer step is 8 and 32 words;
- the pointers and count return to their programmed values after the zero-count block;
- the programmed values stay frozen while running;
- rejected or idle-time messages leave the pointers still.

Only the bench scenarios can show the block-level results:
- a count of N really yields N+1 blocks between interrupts;
- the filter bitmap selects exactly the enabled terminals, with the correct bit for each;
- a start-of-run reload takes the programmed values after the block has been idle.

// File: rtl/bm_seq_pkg.sv
package bm_seq_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_FLT_LO = 3'd1,
    SEL_FLT_HI = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_CMD    = 3'd4,
    SEL_DATA   = 3'd5
  } bm_sel_e;

  localparam int MODE_BIT = 5;
endpackage

// File: rtl/bm_rt_filter.sv
module bm_rt_filter
  import bm_seq_pkg::*;
#(
  parameter int NUM_RT = 32,
  parameter int WORD_W = 16,
  localparam int RT_W   = $clog2(NUM_RT),
  localparam int NWORDS = NUM_RT / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [RT_W-1:0]   rt,
  output logic              pass
);
  logic [NUM_RT-1:0] flt_q;
  logic              mode_q;

  // Each filter word has its own select, starting at the low filter word
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        flt_q[g*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_sel == 3'(int'(SEL_FLT_LO) + g))
        flt_q[g*WORD_W +: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_CTRL)
      mode_q <= wr_data[MODE_BIT];
  end

  assign pass = !mode_q || flt_q[rt];
endmodule

// File: rtl/bm_ptr_gen.sv
module bm_ptr_gen
  import bm_seq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int CMD_STRIDE  = 8,
  parameter int DATA_STRIDE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lock,
  input  logic              load,
  input  logic              adv,
  output logic [ADDR_W-1:0] cmd_ptr,
  output logic [ADDR_W-1:0] data_ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] CSTEP = ADDR_W'(CMD_STRIDE);
  localparam logic [ADDR_W-1:0] DSTEP = ADDR_W'(DATA_STRIDE);

  logic [ADDR_W-1:0] cmd_init, data_init;
  logic [CNT_W-1:0]  cnt_init;
  logic              wr_ok;

  assign wr_ok = wr_en && !lock;
  assign wrap  = adv && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_init  <= '0;
      data_init <= '0;
      cnt_init  <= '0;
      cmd_ptr   <= '0;
      data_ptr  <= '0;
      cnt       <= '0;
    end else if (wr_ok) begin
      case (wr_sel)
        SEL_COUNT: begin cnt_init  <= CNT_W'(wr_data);  cnt      <= CNT_W'(wr_data);  end
        SEL_CMD:   begin cmd_init  <= ADDR_W'(wr_data); cmd_ptr  <= ADDR_W'(wr_data); end
        SEL_DATA:  begin data_init <= ADDR_W'(wr_data); data_ptr <= ADDR_W'(wr_data); end
        default: ;
      endcase
    end else if (load) begin
      cmd_ptr  <= cmd_init;
      data_ptr <= data_init;
      cnt      <= cnt_init;
    end else if (adv) begin
      if (wrap) begin
        cmd_ptr  <= cmd_init;
        data_ptr <= data_init;
        cnt      <= cnt_init;
      end else begin
        cmd_ptr  <= cmd_ptr + CSTEP;
        data_ptr <= data_ptr + DSTEP;
        cnt      <= cnt - 1'b1;
      end
    end
  end

  // R4: fixed record strides and a one-step countdown
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_ok && !load && cnt != '0) |=>
      (cmd_ptr == ADDR_W'($past(cmd_ptr) + CSTEP)) &&
      (data_ptr == ADDR_W'($past(data_ptr) + DSTEP)) &&
      (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R7: zero-count block restarts both pointers and the count
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_ok && !load) |=>
      (cmd_ptr == cmd_init) && (data_ptr == data_init) && (cnt == cnt_init));

  // R8: programmed values frozen while running
  a_r8_init_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cmd_init) && $stable(data_init) && $stable(cnt_init));
endmodule

// File: rtl/bm_log_seq.sv
module bm_log_seq
  import bm_seq_pkg::*;
#(
  parameter int NUM_RT      = 32,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int CMD_STRIDE  = 8,
  parameter int DATA_STRIDE = 32,
  localparam int RT_W       = $clog2(NUM_RT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              run,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [RT_W-1:0]   msg_rt,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [ADDR_W-1:0] blk_cmd_addr,
  output logic [ADDR_W-1:0] blk_data_addr,
  output logic              cnt_irq
);
  logic              run_q, load, log_en, accept, pass, adv, wrap;
  logic [ADDR_W-1:0] cmd_ptr, data_ptr;
  logic [CNT_W-1:0]  cnt;

  bm_rt_filter #(.NUM_RT(NUM_RT), .WORD_W(WORD_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rt(msg_rt), .pass(pass)
  );

  bm_ptr_gen #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CMD_STRIDE(CMD_STRIDE), .DATA_STRIDE(DATA_STRIDE)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .lock(run), .load(load), .adv(adv),
    .cmd_ptr(cmd_ptr), .data_ptr(data_ptr), .cnt(cnt), .wrap(wrap)
  );

  assign load      = run && !run_q;
  assign log_en    = run && run_q;
  assign msg_ready = !blk_valid || blk_ready;
  assign accept    = msg_valid && msg_ready;
  assign adv       = accept && log_en && pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q         <= 1'b0;
      blk_valid     <= 1'b0;
      blk_cmd_addr  <= '0;
      blk_data_addr <= '0;
      cnt_irq       <= 1'b0;
    end else begin
      run_q   <= run;
      cnt_irq <= adv && wrap;
      if (adv) begin
        blk_valid     <= 1'b1;
        blk_cmd_addr  <= cmd_ptr;
        blk_data_addr <= data_ptr;
      end else if (blk_ready) begin
        blk_valid <= 1'b0;
      end
    end
  end

  // R9: stalled descriptor holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready) |=>
      blk_valid && $stable(blk_cmd_addr) && $stable(blk_data_addr));

  // R6: expiry pulse only alongside a descriptor
  a_r6_irq_with_blk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_irq |-> blk_valid);

  // R3: rejected message moves nothing
  a_r3_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && log_en && !pass) |=>
      $stable(cmd_ptr) && $stable(data_ptr) && $stable(cnt) && !cnt_irq);

  // R10: idle-time messages move nothing
  a_r10_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !run && !wr_en) |=> $stable(cmd_ptr) && $stable(cnt));
endmodule

// File: tb/bm_log_seq_tb_top.sv
module bm_log_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en, run, msg_valid, msg_ready, blk_valid, blk_ready, cnt_irq;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data, blk_cmd_addr, blk_data_addr;
  logic [4:0]  msg_rt;

  bm_log_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_rt(msg_rt),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_cmd_addr(blk_cmd_addr),
    .blk_data_addr(blk_data_addr), .cnt_irq(cnt_irq)
  );

  int checks = 0, errors = 0, blk_seen = 0, irq_seen = 0;
  string tag = "R1";

  // behavioural reference state
  logic [15:0] m_cp, m_dp, m_cnt, m_ci, m_di, m_ni, m_bc, m_bd;
  logic [31:0] m_flt;
  logic        m_mode, m_runq, m_bv, m_irq;

  task automatic chk(string t, string f, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", t, f, got, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "blk_valid", {31'd0, blk_valid}, {31'd0, m_bv});
    chk(tag, "cnt_irq", {31'd0, cnt_irq}, {31'd0, m_irq});
    chk(tag, "msg_ready", {31'd0, msg_ready}, {31'd0, (!m_bv || blk_ready)});
    if (m_bv) begin
      chk(tag, "blk_cmd_addr", {16'd0, blk_cmd_addr}, {16'd0, m_bc});
      chk(tag, "blk_data_addr", {16'd0, blk_data_addr}, {16'd0, m_bd});
    end
  endtask

  task automatic cyc(bit mv, int rt, bit we = 0, int sel = 0, int d = 0);
    bit rdy, acc, ld, lg, ps, adv;
    msg_valid = mv; msg_rt = rt[4:0];
    wr_en = we; wr_sel = sel[2:0]; wr_data = d[15:0];
    if (blk_valid && blk_ready) blk_seen++;
    rdy = !m_bv || blk_ready;
    acc = mv && rdy;
    ld  = run && !m_runq;
    lg  = run && m_runq;
    ps  = !m_mode || m_flt[rt];
    adv = acc && lg && ps;
    if (adv) begin
      m_bv = 1'b1; m_bc = m_cp; m_bd = m_dp; m_irq = (m_cnt == 16'd0);
    end else begin
      if (blk_ready) m_bv = 1'b0;
      m_irq = 1'b0;
    end
    if (we && !run) begin
      if (sel == 3) begin m_ni = d[15:0]; m_cnt = d[15:0]; end
      if (sel == 4) begin m_ci = d[15:0]; m_cp = d[15:0]; end
      if (sel == 5) begin m_di = d[15:0]; m_dp = d[15:0]; end
    end else if (ld) begin
      m_cp = m_ci; m_dp = m_di; m_cnt = m_ni;
    end else if (adv) begin
      if (m_cnt == 16'd0) begin
        m_cp = m_ci; m_dp = m_di; m_cnt = m_ni;
      end else begin
        m_cp = m_cp + 16'd8; m_dp = m_dp + 16'd32; m_cnt = m_cnt - 16'd1;
      end
    end
    if (we && sel == 0) m_mode = d[5];
    if (we && sel == 1) m_flt[15:0] = d[15:0];
    if (we && sel == 2) m_flt[31:16] = d[15:0];
    m_runq = run;
    @(negedge clk);
    if (cnt_irq) irq_seen++;
    compare();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; run = 0; blk_ready = 1; msg_valid = 0; msg_rt = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    {m_cp, m_dp, m_cnt, m_ci, m_di, m_ni, m_bc, m_bd} = '0;
    m_flt = '0; m_mode = 0; m_runq = 0; m_bv = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    compare();
    chk("R1", "reset blk_valid", {31'd0, blk_valid}, 32'd0);

    // R5 R4 R7: count 3 gives 4 blocks per round
    tag = "R4";
    cyc(0, 0, 1, 4, 'h0100);
    cyc(0, 0, 1, 5, 'h2000);
    cyc(0, 0, 1, 3, 3);
    cyc(0, 0, 1, 0, 0);
    run = 1;
    cyc(0, 0);
    blk_seen = 0; irq_seen = 0;
    tag = "R7";
    for (int i = 0; i < 7; i++) cyc(1, 3);
    cyc(0, 0);
    chk("R5", "irqs after 7 blocks", irq_seen, 1);
    cyc(1, 3);
    cyc(0, 0); cyc(0, 0);
    chk("R5", "blocks logged", blk_seen, 8);
    chk("R6", "irqs after 8 blocks", irq_seen, 2);

    // R9: back-pressure pattern
    tag = "R9";
    for (int i = 0; i < 24; i++) begin
      blk_ready = (i % 3 == 0);
      cyc(1, i % 32);
    end
    blk_ready = 1;
    cyc(0, 0); cyc(0, 0);

    // R3 R2: filtered capture, terminals 0, 2 and 31 enabled
    tag = "R3";
    cyc(0, 0, 1, 1, 'h0005);
    cyc(0, 0, 1, 2, 'h8000);
    cyc(0, 0, 1, 0, 'h0020);
    blk_seen = 0;
    for (int rt = 0; rt < 32; rt++) cyc(1, rt);
    cyc(0, 0); cyc(0, 0);
    chk("R3", "filtered blocks", blk_seen, 3);
    tag = "R2";
    cyc(0, 0, 1, 0, 'h0000);
    blk_seen = 0;
    for (int i = 0; i < 4; i++) cyc(1, 1);
    cyc(0, 0); cyc(0, 0);
    chk("R2", "all-terminal blocks", blk_seen, 4);

    // R8: count and pointer writes ignored while running
    tag = "R8";
    cyc(0, 0, 1, 3, 0);
    cyc(0, 0, 1, 4, 'h7777);
    for (int i = 0; i < 6; i++) cyc(1, 9);
    cyc(0, 0); cyc(0, 0);

    // R10: idle messages dropped
    tag = "R10";
    run = 0;
    cyc(0, 0);
    blk_seen = 0;
    for (int i = 0; i < 5; i++) cyc(1, 4);
    cyc(0, 0);
    chk("R10", "blocks while idle", blk_seen, 0);

    // R6 R8: count 0 reloaded at run start, every block expires
    tag = "R6";
    cyc(0, 0, 1, 3, 0);
    cyc(0, 0, 1, 4, 'hFFF8);
    cyc(0, 0, 1, 5, 'h0040);
    run = 1;
    cyc(1, 2);
    irq_seen = 0;
    for (int i = 0; i < 3; i++) cyc(1, 2);
    cyc(0, 0); cyc(0, 0);
    chk("R6", "irq per block at count 0", irq_seen, 3);

    // R4: stride wraps modulo 2^16
    tag = "R4";
    run = 0;
    cyc(0, 0, 1, 3, 2);
    run = 1;
    cyc(0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 7);
    cyc(0, 0); cyc(0, 0);

    finish_run();
  end
endmodule